// File: doc/BRIEF.md
# Parallel Laser Lane Power Sequencer

This block controls the lane-enable bits of a twelve-lane laser transmitter. It reads a small set of slow control pins and per-lane fault flags, and it decides when each lane may emit light. Every asynchronous input passes through a two-flop synchroniser. A single prescaled tick then times every interval in the block.

When the supply-good indication rises, the block waits out a power-on interval. It then switches the lanes on one at a time, starting at lane 0, with a fixed number of ticks between neighbours. The lanes go off when any of the following happens:
- the run pin is held low long enough to qualify;
- the stop pin is held high long enough to qualify;
- the control reset pin is held low long enough to be recognised;
- the supply drops;
- a fault is latched.

A fault comes from an over-current, over-temperature or corrupt-calibration flag on any lane. The fault pulls the active-low alarm output low one cycle before the lanes are cleared. It stays latched until a recognised control reset or a supply drop. After any such shutdown, the block waits a restart interval and then ramps the lanes up again in order.

There is no data path. All pins are plain levels with no handshake. The default pin levels (run high, stop low, reset high) let the lanes run.

Top module: `laser_lane_ctrl`

## Requirements
- R1: While `arst_n` is low, `lane_en_o` is all zeros and `alarm_n_o` is 1.
- R2: Each control and flag input acts on the block through a two-flop synchroniser. Output behaviour matches a cycle-exact model that includes this two-cycle latency.
- R3: After the synchronised supply-good level rises, all lanes stay off for INIT_TICKS tick pulses. At the end of that wait, only lane 0 (bit 0 of `lane_en_o`) turns on.
- R4: Lanes turn on strictly in ascending bit order, one lane every STAGGER_TICKS tick pulses (STAGGER_TICKS*TICK_DIV clock cycles apart). `lane_en_o` is always a run of ones starting at bit 0.
- R5: If `link_on_i` is low or `link_off_i` is high for QUAL_TICKS tick pulses in a row, all lanes are forced off in the following cycle.
- R6: A disabling level on `link_on_i` or `link_off_i` that lasts fewer than QUAL_TICKS-1 tick periods has no effect on `lane_en_o`.
- R7: Once every shutdown cause is gone, the lanes stay off for RESTART_TICKS tick pulses and then ramp up as in R4.
- R8: A 1 on any bit of `overcur_i`, `overtemp_i` or `calbad_i` latches a fault: `alarm_n_o` goes to 0, and in the next cycle `lane_en_o` goes to all zeros.
- R9: A latched fault holds `alarm_n_o` at 0 and all lanes off, even after every flag returns to 0. It is released only as R10 or R12 describe.
- R10: When `ctl_rst_n_i` is low for RST_CYCLES synchronised cycles in a row, the block forces the lanes off and releases `alarm_n_o` to 1 for as long as the pin stays low. A shorter low pulse is ignored.
- R11: A recognised control reset has priority over fault flags. A flag raised while reset is active latches nothing.
- R12: A low supply-good level turns all lanes off and releases any fault. The next power-up waits INIT_TICKS as in R3, not RESTART_TICKS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| arst_n | input | 1 | Asynchronous chip reset, active low |
| link_on_i | input | 1 | Run request; a low level asks for shutdown |
| link_off_i | input | 1 | Stop request; a high level asks for shutdown |
| ctl_rst_n_i | input | 1 | Control reset pin, active low |
| supply_ok_i | input | 1 | Supply above its good threshold |
| overcur_i | input | LANES | Per-lane over-current flag |
| overtemp_i | input | LANES | Per-lane over-temperature flag |
| calbad_i | input | LANES | Per-lane calibration-data corruption flag |
| lane_en_o | output | LANES | Lane enables, bit n drives lane n |
| alarm_n_o | output | 1 | Fault alarm, active low |

## Verification
The sharpest collision is a fault flag and a recognised control reset in the same cycles. The bench holds the reset pin low past qualification and raises a calibration flag in the middle of that window. The block must come out of reset with the alarm released and ramp the lanes up again.

A second overlap is a latched fault with a falling supply-good level. The supply must win: the alarm is cleared and the next power-up uses the long initial wait. Both cases are judged every cycle against the behavioural model and also by directed checks on the alarm and lane outputs.

// File: rtl/laser_lane_pkg.sv
package laser_lane_pkg;

  typedef enum logic [2:0] {
    SQ_OFF,
    SQ_WAIT,
    SQ_HOLD,
    SQ_RAMP,
    SQ_ON
  } seq_state_e;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/llc_sync.sv
module llc_sync #(
  parameter int unsigned WIDTH = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q, stab_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= RST_VAL;
      stab_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      stab_q <= meta_q;
    end
  end

  assign q_o = stab_q;
endmodule

// File: rtl/llc_tick.sv
module llc_tick #(
  parameter int unsigned DIV = 100
) (
  input  logic clk,
  input  logic arst_n,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/llc_hold_qual.sv
module llc_hold_qual #(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk,
  input  logic arst_n,
  input  logic level_i,
  input  logic step_i,
  output logic held_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;
  logic          held_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt_q  <= '0;
      held_q <= 1'b0;
    end else if (!level_i) begin
      cnt_q  <= '0;
      held_q <= 1'b0;
    end else if (!held_q && step_i) begin
      if (cnt_q == LAST) held_q <= 1'b1;
      else cnt_q <= cnt_q + 1'b1;
    end
  end

  assign held_o = held_q;
endmodule

// File: rtl/llc_ramp.sv
module llc_ramp
  import laser_lane_pkg::*;
#(
  parameter int unsigned LANES         = 12,
  parameter int unsigned INIT_TICKS    = 60000,
  parameter int unsigned RESTART_TICKS = 55000,
  parameter int unsigned STAGGER_TICKS = 4600
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             tick_i,
  input  logic             powered_i,
  input  logic             blocked_i,
  output logic [LANES-1:0] lane_en_o
);
  localparam int unsigned MAXT = max3(INIT_TICKS, RESTART_TICKS, STAGGER_TICKS);
  localparam int unsigned WW   = $clog2(MAXT + 1);
  localparam logic [WW-1:0] INIT_LD  = WW'(INIT_TICKS - 1);
  localparam logic [WW-1:0] RSTRT_LD = WW'(RESTART_TICKS - 1);
  localparam logic [WW-1:0] STAG_LD  = WW'(STAGGER_TICKS - 1);

  seq_state_e       st_q;
  logic [WW-1:0]    wait_q;
  logic [LANES-1:0] lanes_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      st_q    <= SQ_OFF;
      wait_q  <= '0;
      lanes_q <= '0;
    end else if (!powered_i) begin
      st_q    <= SQ_OFF;
      wait_q  <= '0;
      lanes_q <= '0;
    end else if (blocked_i) begin
      st_q    <= SQ_HOLD;
      wait_q  <= '0;
      lanes_q <= '0;
    end else begin
      case (st_q)
        SQ_OFF: begin
          st_q   <= SQ_WAIT;
          wait_q <= INIT_LD;
        end
        SQ_HOLD: begin
          st_q   <= SQ_WAIT;
          wait_q <= RSTRT_LD;
        end
        SQ_WAIT: begin
          if (tick_i) begin
            if (wait_q == '0) begin
              st_q    <= SQ_RAMP;
              lanes_q <= LANES'(1);
              wait_q  <= STAG_LD;
            end else begin
              wait_q <= wait_q - 1'b1;
            end
          end
        end
        SQ_RAMP: begin
          if (tick_i) begin
            if (wait_q == '0) begin
              lanes_q <= {lanes_q[LANES-2:0], 1'b1};
              wait_q  <= STAG_LD;
              if (lanes_q[LANES-2]) st_q <= SQ_ON;
            end else begin
              wait_q <= wait_q - 1'b1;
            end
          end
        end
        default: st_q <= SQ_ON;
      endcase
    end
  end

  assign lane_en_o = lanes_q;
endmodule

// File: rtl/laser_lane_ctrl.sv
module laser_lane_ctrl
  import laser_lane_pkg::*;
#(
  parameter int unsigned LANES         = 12,
  parameter int unsigned TICK_DIV      = 100,
  parameter int unsigned QUAL_TICKS    = 1000,
  parameter int unsigned INIT_TICKS    = 60000,
  parameter int unsigned RESTART_TICKS = 55000,
  parameter int unsigned STAGGER_TICKS = 4600,
  parameter int unsigned RST_CYCLES    = 11
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             link_on_i,
  input  logic             link_off_i,
  input  logic             ctl_rst_n_i,
  input  logic             supply_ok_i,
  input  logic [LANES-1:0] overcur_i,
  input  logic [LANES-1:0] overtemp_i,
  input  logic [LANES-1:0] calbad_i,
  output logic [LANES-1:0] lane_en_o,
  output logic             alarm_n_o
);
  localparam int unsigned SW = 4 + 3 * LANES;
  localparam logic [SW-1:0] SYNC_RST = {1'b1, 1'b0, 1'b1, 1'b0, {(3 * LANES){1'b0}}};

  logic [SW-1:0]    raw_in, syn_in;
  logic             on_s, off_s, rstn_s, pg_s;
  logic [LANES-1:0] oc_s, ot_s, cb_s, lane_flag;
  logic             tick, shut_req, rst_act, flt_lat, any_flag;

  assign raw_in = {link_on_i, link_off_i, ctl_rst_n_i, supply_ok_i,
                   overcur_i, overtemp_i, calbad_i};

  llc_sync #(.WIDTH(SW), .RST_VAL(SYNC_RST)) sync_i (
    .clk(clk), .arst_n(arst_n), .d_i(raw_in), .q_o(syn_in)
  );

  assign {on_s, off_s, rstn_s, pg_s, oc_s, ot_s, cb_s} = syn_in;

  for (genvar g = 0; g < LANES; g++) begin : g_lane_flag
    assign lane_flag[g] = oc_s[g] | ot_s[g] | cb_s[g];
  end
  assign any_flag = |lane_flag;

  llc_tick #(.DIV(TICK_DIV)) tick_i (
    .clk(clk), .arst_n(arst_n), .tick_o(tick)
  );

  llc_hold_qual #(.LIMIT(QUAL_TICKS)) shut_qual_i (
    .clk(clk), .arst_n(arst_n), .level_i(!on_s || off_s),
    .step_i(tick), .held_o(shut_req)
  );

  llc_hold_qual #(.LIMIT(RST_CYCLES)) rst_qual_i (
    .clk(clk), .arst_n(arst_n), .level_i(!rstn_s),
    .step_i(1'b1), .held_o(rst_act)
  );

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) flt_lat <= 1'b0;
    else if (rst_act || !pg_s) flt_lat <= 1'b0;
    else if (any_flag) flt_lat <= 1'b1;
  end

  llc_ramp #(
    .LANES(LANES), .INIT_TICKS(INIT_TICKS),
    .RESTART_TICKS(RESTART_TICKS), .STAGGER_TICKS(STAGGER_TICKS)
  ) ramp_i (
    .clk(clk), .arst_n(arst_n), .tick_i(tick), .powered_i(pg_s),
    .blocked_i(rst_act || flt_lat || shut_req), .lane_en_o(lane_en_o)
  );

  assign alarm_n_o = ~flt_lat;
endmodule

// File: rtl/llc_checker.sv
module llc_checker #(
  parameter int unsigned LANES = 12
) (
  input logic             clk,
  input logic             arst_n,
  input logic [LANES-1:0] lane_en,
  input logic             alarm_n,
  input logic             rst_act,
  input logic             pg_s,
  input logic             shut
);
  // R4
  lane_thermo_chk: assert property (@(posedge clk) disable iff (!arst_n)
    ((lane_en & (lane_en + 1'b1)) == '0));

  // R4
  lane_step_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (lane_en != $past(lane_en)) |->
      (lane_en == '0 || lane_en == {$past(lane_en[LANES-2:0]), 1'b1}));

  // R5
  shut_off_chk: assert property (@(posedge clk) disable iff (!arst_n)
    shut |=> (lane_en == '0));

  // R8
  alarm_dark_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (!alarm_n && !$past(alarm_n)) |-> (lane_en == '0));

  // R9
  alarm_hold_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (!alarm_n && !rst_act && pg_s) |=> !alarm_n);

  // R10
  rst_clear_chk: assert property (@(posedge clk) disable iff (!arst_n)
    rst_act |=> (alarm_n && lane_en == '0));

  // R12
  supply_drop_chk: assert property (@(posedge clk) disable iff (!arst_n)
    !pg_s |=> (alarm_n && lane_en == '0));
endmodule

bind laser_lane_ctrl llc_checker #(.LANES(LANES)) chk_i (
  .clk(clk), .arst_n(arst_n), .lane_en(lane_en_o), .alarm_n(alarm_n_o),
  .rst_act(rst_act), .pg_s(pg_s), .shut(shut_req)
);

// File: tb/laser_lane_ctrl_tb_top.sv
module laser_lane_ctrl_tb_top;
  localparam int L = 12, DIV = 4, QUAL = 5, INIT = 10, RSTRT = 6, STAG = 3, RSTC = 4;
  localparam logic [L-1:0] FULL = '1;
  localparam int W = 4 + 3 * L;

  logic clk = 1'b0, arst_n = 1'b0;
  logic r_on = 1'b1, r_off = 1'b0, r_rstn = 1'b1, r_pg = 1'b0;
  logic [L-1:0] r_oc = '0, r_ot = '0, r_cb = '0;
  logic [L-1:0] lane_en;
  logic alarm_n;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  laser_lane_ctrl #(.LANES(L), .TICK_DIV(DIV), .QUAL_TICKS(QUAL), .INIT_TICKS(INIT),
    .RESTART_TICKS(RSTRT), .STAGGER_TICKS(STAG), .RST_CYCLES(RSTC)) dut_i (
    .clk(clk), .arst_n(arst_n), .link_on_i(r_on), .link_off_i(r_off),
    .ctl_rst_n_i(r_rstn), .supply_ok_i(r_pg), .overcur_i(r_oc), .overtemp_i(r_ot),
    .calbad_i(r_cb), .lane_en_o(lane_en), .alarm_n_o(alarm_n));

  // behavioural reference model
  logic [W-1:0] m_d1, m_d2;
  int m_cyc, m_offticks, m_lowcnt, m_phase, m_cd, m_nl;
  bit m_shut, m_ract, m_flt;
  logic [L-1:0] m_lanes;
  assign m_lanes = L'((64'd1 << m_nl) - 64'd1);

  always @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      m_d1 <= {1'b1, 1'b0, 1'b1, 1'b0, {(3*L){1'b0}}};
      m_d2 <= {1'b1, 1'b0, 1'b1, 1'b0, {(3*L){1'b0}}};
      m_cyc = 0; m_offticks = 0; m_lowcnt = 0; m_phase = 0; m_cd = 0; m_nl = 0;
      m_shut = 0; m_ract = 0; m_flt = 0;
    end else begin
      bit s_on, s_off, s_rstn, s_pg, s_any, tk, blocked, n_shut, n_ract, n_flt;
      int n_off, n_low;
      s_on = m_d2[W-1]; s_off = m_d2[W-2]; s_rstn = m_d2[W-3]; s_pg = m_d2[W-4];
      s_any = |m_d2[3*L-1:0];
      tk = ((m_cyc % DIV) == DIV - 1);
      n_shut = m_shut; n_off = m_offticks;
      if (s_on && !s_off) begin n_shut = 0; n_off = 0; end
      else if (!m_shut && tk) begin n_off = m_offticks + 1; if (n_off == QUAL) n_shut = 1; end
      n_ract = m_ract; n_low = m_lowcnt;
      if (s_rstn) begin n_ract = 0; n_low = 0; end
      else if (!m_ract) begin n_low = m_lowcnt + 1; if (n_low == RSTC) n_ract = 1; end
      n_flt = (m_ract || !s_pg) ? 1'b0 : (s_any ? 1'b1 : m_flt);
      blocked = m_ract || m_flt || m_shut;
      if (!s_pg) begin m_phase = 0; m_nl = 0; m_cd = 0; end
      else if (blocked) begin m_phase = 2; m_nl = 0; m_cd = 0; end
      else begin
        case (m_phase)
          0: begin m_phase = 1; m_cd = INIT - 1; end
          2: begin m_phase = 1; m_cd = RSTRT - 1; end
          1: if (tk) begin
               if (m_cd == 0) begin m_phase = 3; m_nl = 1; m_cd = STAG - 1; end
               else m_cd--;
             end
          3: if (tk) begin
               if (m_cd == 0) begin m_nl++; m_cd = STAG - 1; if (m_nl == L) m_phase = 4; end
               else m_cd--;
             end
          default: ;
        endcase
      end
      m_shut = n_shut; m_offticks = n_off; m_ract = n_ract; m_lowcnt = n_low; m_flt = n_flt;
      m_cyc++;
      m_d2 <= m_d1;
      m_d1 <= {r_on, r_off, r_rstn, r_pg, r_oc, r_ot, r_cb};
    end
  end

  // R2: cycle-exact comparison against the model
  always @(negedge clk) begin
    if (arst_n && !done) begin
      checks++;
      if (lane_en !== m_lanes || alarm_n !== !m_flt) begin
        errors++;
        $display("FAIL R2 cycle model: lanes=%h alarm_n=%b expected lanes=%h alarm_n=%b",
                 lane_en, alarm_n, m_lanes, !m_flt);
      end
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_rng(input string tag, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s: actual=%0d expected %0d..%0d", tag, act, lo, hi);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_full(input string tag);
    int n = 0;
    while (lane_en !== FULL && n < 600) begin @(negedge clk); n++; end
    chk(tag, lane_en, FULL);
  endtask

  task automatic time_to_light(output int n);
    n = 0;
    while (lane_en === '0 && n < 600) begin @(negedge clk); n++; end
  endtask

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    int n;
    bit dropped;
    cyc(3);
    chk("R1 reset lanes", lane_en, 0);
    chk("R1 reset alarm", alarm_n, 1);
    arst_n = 1'b1;
    cyc(5);
    chk("R3 no supply lanes off", lane_en, 0);

    // power-up
    r_pg = 1'b1;
    time_to_light(n);
    chk_rng("R3 init delay", n, (INIT-1)*DIV + 3, INIT*DIV + 4);
    chk("R3 lane0 first", lane_en, 1);
    while (!lane_en[1]) @(negedge clk);
    n = 0;
    while (!lane_en[2] && n < 100) begin @(negedge clk); n++; end
    chk("R4 stagger gap", n, STAG*DIV);
    wait_full("R4 all lanes on");

    // short stop pulse ignored
    r_off = 1'b1; cyc(8); r_off = 1'b0;
    dropped = 0;
    repeat (30) begin @(negedge clk); if (lane_en !== FULL) dropped = 1; end
    chk("R6 short stop pulse ignored", dropped, 0);

    // qualified stop
    r_off = 1'b1; cyc(40);
    chk("R5 stop pin shutdown", lane_en, 0);
    r_off = 1'b0;
    time_to_light(n);
    chk_rng("R7 restart delay", n, (RSTRT-1)*DIV + 3, RSTRT*DIV + 6);
    wait_full("R7 ramp after stop");

    // qualified run-pin low
    r_on = 1'b0; cyc(40);
    chk("R5 run pin shutdown", lane_en, 0);
    r_on = 1'b1;
    wait_full("R7 ramp after run");

    // over-current fault on lane 5
    r_oc[5] = 1'b1; cyc(1); r_oc[5] = 1'b0;
    cyc(5);
    chk("R8 alarm asserted", alarm_n, 0);
    chk("R8 lanes dark", lane_en, 0);
    cyc(60);
    chk("R9 fault still latched", alarm_n, 0);
    chk("R9 lanes still dark", lane_en, 0);

    // short reset pulse ignored, then long reset
    r_rstn = 1'b0; cyc(2); r_rstn = 1'b1; cyc(10);
    chk("R10 short reset ignored", alarm_n, 0);
    r_rstn = 1'b0; cyc(12);
    chk("R10 reset releases alarm", alarm_n, 1);
    chk("R10 reset lanes dark", lane_en, 0);
    r_rstn = 1'b1;
    time_to_light(n);
    chk_rng("R7 restart after reset", n, (RSTRT-1)*DIV + 3, RSTRT*DIV + 6);
    wait_full("R10 ramp after reset");

    // flag raised during active reset
    r_rstn = 1'b0; cyc(8);
    r_cb[11] = 1'b1; cyc(3); r_cb[11] = 1'b0; cyc(3);
    chk("R11 flag under reset ignored", alarm_n, 1);
    r_rstn = 1'b1; cyc(10);
    chk("R11 alarm stays released", alarm_n, 1);
    wait_full("R11 ramp after reset");

    // over-temperature fault, then supply drop
    r_ot[0] = 1'b1; cyc(1); r_ot[0] = 1'b0; cyc(5);
    chk("R8 overtemp alarm", alarm_n, 0);
    r_pg = 1'b0; cyc(6);
    chk("R12 supply drop releases alarm", alarm_n, 1);
    chk("R12 supply drop lanes dark", lane_en, 0);
    r_pg = 1'b1;
    time_to_light(n);
    chk_rng("R12 long init after drop", n, (INIT-1)*DIV + 3, INIT*DIV + 4);
    wait_full("R12 ramp after power");

    cyc(5);
    done = 1;
    summary();
    $finish;
  end
endmodule